// File: doc/BRIEF.md
# Background Memory Scrubber with Upset Classification

The scrubber walks a protected memory of `FRAMES` frames of `WORDS` codewords each, one frame per scan tick, while the surrounding design continues to use the memory. Every codeword carries a SECDED code. A single upset is repaired by writing the corrected codeword back in place. A double upset is reported and the word is left as it is. Alongside the per-word check, a 32-bit CRC is accumulated over the data of the whole array in address order. At the end of each full pass that CRC is compared with a reference, which is captured during the first pass after reset.

Each repaired upset is classified through a mask-lookup port. The port returns whether the exact stored bit is essential to the design. A non-essential hit yields only a benign report. An essential hit also pulses a critical alarm. Reports leave the block as records on a valid/ready channel.

A heartbeat output toggles at the end of every frame. Scan ticks come from an internal divider or from an external input, chosen by a select pin. A fault-injection command flips one chosen stored bit so that the detection and reporting path can be exercised in the field.

Top module: `scrub_engine`

## Requirements
- R1: After reset `ev_valid`, `crit_alarm`, `heartbeat`, `mem_rd` and `mem_wr` are all low, and no memory access occurs until a scan tick or an injection command arrives.
- R2: Each scan tick checks one frame. Its words are read at addresses `frame*WORDS+word` in increasing word order. Frames are taken in increasing order and wrap to frame 0 after the last. The read port and the write port are never active in the same cycle.
- R3: The stored codeword holds data in bits [31:0]. Check bit j, stored in bit 32+j, is the parity of the data bits whose column code has bit j set. The column codes are the values 3, 5, 6, 7, 9, ... (ascending, powers of two skipped), assigned to data bits 0 to 31. Bit 38 makes the parity of all 39 bits even. Any single flipped bit (0 to 38) is corrected, the repaired codeword is written back, and a record is issued with type 1 and the flipped bit index.
- R4: Two flipped bits in one word produce a record of type 2 with the essential flag set, and there is no write to that word.
- R5: The CRC (polynomial 0x04C11DB7, seed all ones, data MSB first) runs over the corrected data of each word, or the raw data of an uncorrectable word. The first pass after reset stores the reference and never reports. On each later pass, a mismatch produces a record of type 3 (frame 0, word 0, essential set) after the last frame. A pass whose data all matches produces no record.
- R6: `heartbeat` toggles exactly once per completed frame and at no other time.
- R7: With `use_ext_tick` high, only `ext_tick` pulses start frames. With it low, frames start every `TICK_DIV` cycles from the internal divider.
- R8: For a corrected upset, the mask is read at the word address and bit index. The record's essential flag equals the returned bit, and `crit_alarm` pulses for one cycle only when that flag is set.
- R9: A record stays valid with all fields unchanged until `ev_ready` is high. The scan does not proceed past a pending record.
- R10: An injection command is accepted only while no frame is in progress, takes priority over a pending tick, and flips exactly the addressed stored bit through a read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_ext_tick | input | 1 | 1: scan ticks from `ext_tick`; 0: internal divider |
| ext_tick | input | 1 | External scan tick, one-cycle pulse |
| mem_rd | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word address for read or write |
| mem_wdata | output | 39 | Codeword to write |
| mem_rdata | input | 39 | Codeword read, one cycle after `mem_rd` |
| mask_rd | output | 1 | Essential-mask lookup strobe; answer next cycle |
| mask_addr | output | AW | Word address of the looked-up bit |
| mask_bit | output | 6 | Codeword bit index of the looked-up bit |
| mask_ess | input | 1 | 1 when the looked-up bit is essential |
| ev_valid | output | 1 | Report record valid |
| ev_ready | input | 1 | Report record accepted |
| ev_type | output | 2 | 1 corrected, 2 uncorrectable, 3 CRC mismatch |
| ev_frame | output | FW | Frame index of the event |
| ev_word | output | WW | Word index within the frame |
| ev_bit | output | 6 | Corrected bit index (0 otherwise) |
| ev_essential | output | 1 | Essential classification |
| crit_alarm | output | 1 | One-cycle pulse for an essential event |
| heartbeat | output | 1 | Toggles at each frame end |
| inj_valid | input | 1 | Injection command valid |
| inj_ready | output | 1 | Injection command can be accepted |
| inj_frame | input | FW | Frame of the bit to flip |
| inj_word | input | WW | Word of the bit to flip |
| inj_bit | input | 6 | Codeword bit to flip |

## Verification
An injection command and a scan tick can arrive in the same idle cycle. The bench provokes this by raising `inj_valid` and `ext_tick` together just before frame 0 is due. The outcome is judged correct only if the flip lands first and that very frame then finds it. The frame must report the injected bit with its frame, word and classification and leave the word repaired. A second overlap, between a report stalled by `ev_ready` and further upsets in the same frame, is judged by the held record's fields and the heartbeat both staying frozen until the stall is released.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CODE_W = 39;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_CORR   = 2'd1,
    EV_UNCORR = 2'd2,
    EV_CRC    = 2'd3
  } ev_kind_e;

  // column code of data bit idx: idx-th value >= 3 that is not a power of two
  function automatic logic [5:0] col_code(input int idx);
    int k;
    logic [5:0] r;
    k = 0;
    r = '0;
    for (int v = 3; v < 64; v++) begin
      if ((v & (v - 1)) != 0) begin
        if (k == idx) r = 6'(v);
        k++;
      end
    end
    return r;
  endfunction

  function automatic logic [5:0] syndrome(input logic [CODE_W-1:0] cw);
    logic [5:0] s;
    s = '0;
    for (int i = 0; i < DATA_W; i++)
      if (cw[i]) s ^= col_code(i);
    for (int j = 0; j < CHK_W; j++)
      if (cw[DATA_W+j]) s[j] = ~s[j];
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] cw;
    cw = {1'b0, 6'b0, d};
    cw[37:32] = syndrome(cw);
    cw[38] = ^cw[37:0];
    return cw;
  endfunction

  // 63 marks a syndrome that names no bit
  function automatic logic [5:0] syn_to_pos(input logic [5:0] s);
    logic [5:0] r;
    r = 6'd63;
    if (s == 6'd0) r = 6'd38;
    for (int j = 0; j < CHK_W; j++)
      if (s == 6'(1 << j)) r = 6'(DATA_W + j);
    for (int i = 0; i < DATA_W; i++)
      if (s == col_code(i)) r = 6'(i);
    return r;
  endfunction

  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int b = 31; b >= 0; b--) begin
      fb = r[31] ^ d[b];
      r = {r[30:0], 1'b0};
      if (fb) r ^= CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/scrub_tick.sv
module scrub_tick #(
  parameter int DIV = 4096,
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_ext,
  input  logic ext_tick,
  output logic tick
);
  logic [CW-1:0] cnt;
  logic int_tick;

  assign int_tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (int_tick) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign tick = use_ext ? ext_tick : int_tick;
endmodule

// File: rtl/scrub_crc_acc.sv
module scrub_crc_acc
  import scrub_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [31:0] din,
  output logic [31:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= CRC_SEED;
    else if (en)       crc <= crc32_word(crc, din);
  end
endmodule

// File: rtl/scrub_secded_dec.sv
module scrub_secded_dec
  import scrub_pkg::*;
(
  input  logic [CODE_W-1:0] cw,
  output logic [DATA_W-1:0] data_fix,
  output logic [CODE_W-1:0] cw_fix,
  output logic              err_single,
  output logic              err_double,
  output logic [5:0]        bit_pos
);
  logic [5:0] syn;
  logic       par;

  always_comb begin
    syn        = syndrome(cw);
    par        = ^cw;
    bit_pos    = syn_to_pos(syn);
    err_single = par && (bit_pos != 6'd63);
    err_double = (!par && (syn != 6'd0)) || (par && (bit_pos == 6'd63));
    cw_fix     = err_single ? (cw ^ (CODE_W'(1) << bit_pos)) : cw;
    data_fix   = cw_fix[DATA_W-1:0];
  end

  always_comb begin
    assert_one_kind_R3: assert (!(err_single && err_double));
  end
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int FRAMES   = 8,
  parameter int WORDS    = 16,
  parameter int TICK_DIV = 4096,
  localparam int FW = (FRAMES > 2) ? $clog2(FRAMES) : 1,
  localparam int WW = (WORDS > 2) ? $clog2(WORDS) : 1,
  localparam int AW = $clog2(FRAMES * WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_ext_tick,
  input  logic              ext_tick,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [CODE_W-1:0] mem_wdata,
  input  logic [CODE_W-1:0] mem_rdata,
  output logic              mask_rd,
  output logic [AW-1:0]     mask_addr,
  output logic [5:0]        mask_bit,
  input  logic              mask_ess,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [1:0]        ev_type,
  output logic [FW-1:0]     ev_frame,
  output logic [WW-1:0]     ev_word,
  output logic [5:0]        ev_bit,
  output logic              ev_essential,
  output logic              crit_alarm,
  output logic              heartbeat,
  input  logic              inj_valid,
  output logic              inj_ready,
  input  logic [FW-1:0]     inj_frame,
  input  logic [WW-1:0]     inj_word,
  input  logic [5:0]        inj_bit
);
  typedef enum logic [3:0] {
    S_IDLE, S_INJ_RD, S_INJ_WR, S_RD, S_CHK, S_MASK,
    S_FIX, S_EVT, S_NEXT, S_PASS, S_DONE
  } st_e;

  st_e               state;
  logic [FW-1:0]     frame_q;
  logic [WW-1:0]     word_q;
  logic              tick_pend;
  logic [FW-1:0]     inj_f;
  logic [WW-1:0]     inj_w;
  logic [5:0]        inj_b;
  logic [CODE_W-1:0] cw_q;
  logic [5:0]        pos_q;
  logic              evt_pass;
  logic [31:0]       ref_q;
  logic              ref_ok;
  ev_kind_e          ev_kind_q;

  // named internal events
  logic              tick;
  logic              frame_start;
  logic              inj_accept;
  logic              inj_wr_fire;
  logic              last_word;
  logic              last_frame;
  logic [AW-1:0]     cur_addr;
  logic [AW-1:0]     inj_addr;

  logic [DATA_W-1:0] dec_data;
  logic [CODE_W-1:0] dec_cw;
  logic              dec_single;
  logic              dec_double;
  logic [5:0]        dec_pos;
  logic [31:0]       crc_now;

  scrub_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .use_ext(use_ext_tick),
    .ext_tick(ext_tick), .tick(tick)
  );

  scrub_secded_dec u_dec (
    .cw(mem_rdata), .data_fix(dec_data), .cw_fix(dec_cw),
    .err_single(dec_single), .err_double(dec_double), .bit_pos(dec_pos)
  );

  scrub_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(state == S_PASS),
    .en(state == S_CHK), .din(dec_data), .crc(crc_now)
  );

  assign cur_addr    = AW'(frame_q) * AW'(WORDS) + AW'(word_q);
  assign inj_addr    = AW'(inj_f) * AW'(WORDS) + AW'(inj_w);
  assign last_word   = (word_q == WW'(WORDS - 1));
  assign last_frame  = (frame_q == FW'(FRAMES - 1));
  assign inj_ready   = (state == S_IDLE);
  assign inj_accept  = inj_ready && inj_valid;
  assign frame_start = inj_ready && !inj_valid && tick_pend;
  assign inj_wr_fire = (state == S_INJ_WR);

  assign mem_rd    = (state == S_RD) || (state == S_INJ_RD);
  assign mem_wr    = (state == S_FIX) || inj_wr_fire;
  assign mem_addr  = ((state == S_INJ_RD) || inj_wr_fire) ? inj_addr : cur_addr;
  assign mem_wdata = inj_wr_fire ? (mem_rdata ^ (CODE_W'(1) << inj_b)) : cw_q;
  assign mask_rd   = (state == S_MASK);
  assign mask_addr = cur_addr;
  assign mask_bit  = pos_q;
  assign ev_valid  = (state == S_EVT);
  assign ev_type   = ev_kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           tick_pend <= 1'b0;
    else if (tick)        tick_pend <= 1'b1;
    else if (frame_start) tick_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      frame_q      <= '0;
      word_q       <= '0;
      inj_f        <= '0;
      inj_w        <= '0;
      inj_b        <= '0;
      cw_q         <= '0;
      pos_q        <= '0;
      evt_pass     <= 1'b0;
      ref_q        <= '0;
      ref_ok       <= 1'b0;
      ev_kind_q    <= EV_NONE;
      ev_frame     <= '0;
      ev_word      <= '0;
      ev_bit       <= '0;
      ev_essential <= 1'b0;
      crit_alarm   <= 1'b0;
      heartbeat    <= 1'b0;
    end else begin
      crit_alarm <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (inj_accept) begin
            inj_f <= inj_frame;
            inj_w <= inj_word;
            inj_b <= inj_bit;
            state <= S_INJ_RD;
          end else if (frame_start) begin
            state <= S_RD;
          end
        end
        S_INJ_RD: state <= S_INJ_WR;
        S_INJ_WR: state <= S_IDLE;
        S_RD:     state <= S_CHK;
        S_CHK: begin
          cw_q  <= dec_cw;
          pos_q <= dec_pos;
          if (dec_single) begin
            state <= S_MASK;
          end else if (dec_double) begin
            ev_kind_q    <= EV_UNCORR;
            ev_frame     <= frame_q;
            ev_word      <= word_q;
            ev_bit       <= '0;
            ev_essential <= 1'b1;
            crit_alarm   <= 1'b1;
            evt_pass     <= 1'b0;
            state        <= S_EVT;
          end else begin
            state <= S_NEXT;
          end
        end
        S_MASK: state <= S_FIX;
        S_FIX: begin
          ev_kind_q    <= EV_CORR;
          ev_frame     <= frame_q;
          ev_word      <= word_q;
          ev_bit       <= pos_q;
          ev_essential <= mask_ess;
          crit_alarm   <= mask_ess;
          evt_pass     <= 1'b0;
          state        <= S_EVT;
        end
        S_EVT: begin
          if (ev_ready) state <= evt_pass ? S_DONE : S_NEXT;
        end
        S_NEXT: begin
          if (last_word) begin
            word_q <= '0;
            if (last_frame) begin
              state <= S_PASS;
            end else begin
              frame_q <= frame_q + 1'b1;
              state   <= S_DONE;
            end
          end else begin
            word_q <= word_q + 1'b1;
            state  <= S_RD;
          end
        end
        S_PASS: begin
          frame_q <= '0;
          if (!ref_ok) begin
            ref_q  <= crc_now;
            ref_ok <= 1'b1;
            state  <= S_DONE;
          end else if (crc_now != ref_q) begin
            ev_kind_q    <= EV_CRC;
            ev_frame     <= '0;
            ev_word      <= '0;
            ev_bit       <= '0;
            ev_essential <= 1'b1;
            crit_alarm   <= 1'b1;
            evt_pass     <= 1'b1;
            state        <= S_EVT;
          end else begin
            state <= S_DONE;
          end
        end
        S_DONE: begin
          heartbeat <= ~heartbeat;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_crc_after_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_type == EV_CRC) |-> ref_ok);

  assert_hb_frame_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (heartbeat != $past(heartbeat)) |-> $past(state == S_DONE));

  assert_fix_after_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !inj_wr_fire) |-> $past(mask_rd));

  assert_crit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crit_alarm |-> (ev_valid && ev_essential));

  assert_evt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_type) && $stable(ev_frame)
                                 && $stable(ev_word) && $stable(ev_bit)
                                 && $stable(ev_essential)));

  assert_inj_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inj_wr_fire |-> ($past(inj_ready, 2) && word_q == '0));
endmodule

// File: tb/scrub_engine_test.sv
`timescale 1ns/1ps
module scrub_engine_test;
  localparam int NF  = 4;
  localparam int NW  = 4;
  localparam int NA  = NF * NW;
  localparam int DIV = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        use_ext_tick = 1'b1;
  logic        ext_tick = 1'b0;
  logic        mem_rd, mem_wr;
  logic [3:0]  mem_addr;
  logic [38:0] mem_wdata;
  logic [38:0] mem_rdata = '0;
  logic        mask_rd;
  logic [3:0]  mask_addr;
  logic [5:0]  mask_bit;
  logic        mask_ess = 1'b0;
  logic        ev_valid;
  logic        ev_ready = 1'b1;
  logic [1:0]  ev_type;
  logic [1:0]  ev_frame;
  logic [1:0]  ev_word;
  logic [5:0]  ev_bit;
  logic        ev_essential;
  logic        crit_alarm;
  logic        heartbeat;
  logic        inj_valid = 1'b0;
  logic        inj_ready;
  logic [1:0]  inj_frame = '0;
  logic [1:0]  inj_word = '0;
  logic [5:0]  inj_bit = '0;

  scrub_engine #(.FRAMES(NF), .WORDS(NW), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .use_ext_tick(use_ext_tick), .ext_tick(ext_tick),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mask_rd(mask_rd), .mask_addr(mask_addr),
    .mask_bit(mask_bit), .mask_ess(mask_ess), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_type(ev_type), .ev_frame(ev_frame), .ev_word(ev_word),
    .ev_bit(ev_bit), .ev_essential(ev_essential), .crit_alarm(crit_alarm),
    .heartbeat(heartbeat), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_frame(inj_frame), .inj_word(inj_word), .inj_bit(inj_bit)
  );

  logic [38:0] mem  [NA];
  logic [38:0] gold [NA];
  logic [5:0]  colt [32];

  int checks = 0;
  int errors = 0;

  function automatic logic ess_model(input int a, input int b);
    return ((a * 7 + b) % 3) == 0;
  endfunction

  function automatic logic [38:0] enc(input logic [31:0] d);
    logic [5:0] c;
    c = '0;
    for (int j = 0; j < 6; j++)
      for (int i = 0; i < 32; i++)
        if (colt[i][j] && d[i]) c[j] = ~c[j];
    return {^{c, d}, c, d};
  endfunction

  // memory and mask models
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mask_rd) mask_ess <= ess_model(int'(mask_addr), int'(mask_bit));
  end

  // monitors, sampled between edges
  int nev = 0, ncrit = 0, nwr = 0, nrd = 0, hb_tog = 0;
  logic hb_last = 1'b0;
  logic [1:0] r_type [8];
  logic [1:0] r_frame [8];
  logic [1:0] r_word [8];
  logic [5:0] r_bit [8];
  logic       r_ess [8];
  logic [3:0] rd_log [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (ev_valid && ev_ready) begin
        r_type[nev & 7]  = ev_type;
        r_frame[nev & 7] = ev_frame;
        r_word[nev & 7]  = ev_word;
        r_bit[nev & 7]   = ev_bit;
        r_ess[nev & 7]   = ev_essential;
        nev++;
      end
      if (crit_alarm) ncrit++;
      if (mem_wr) nwr++;
      if (mem_rd) begin
        if (nrd < 64) rd_log[nrd] = mem_addr;
        nrd++;
      end
      if (heartbeat != hb_last) begin
        hb_tog++;
        hb_last = heartbeat;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame();
    logic hb0;
    hb0 = heartbeat;
    @(negedge clk) ext_tick = 1'b1;
    @(negedge clk) ext_tick = 1'b0;
    while (heartbeat == hb0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pass();
    repeat (NF) run_frame();
  endtask

  task automatic inject(input int f, input int w, input int b);
    @(negedge clk);
    while (!inj_ready) @(negedge clk);
    inj_frame = 2'(f); inj_word = 2'(w); inj_bit = 6'(b); inj_valid = 1'b1;
    @(negedge clk) inj_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, e0, c0, w0, t0, a;
    logic ee;
    k = 0;
    for (int v = 1; v < 64; v++)
      if ((v & (v - 1)) != 0 && k < 32) begin colt[k] = 6'(v); k++; end
    for (int i = 0; i < NA; i++) begin
      gold[i] = enc(32'hC0DE_0000 ^ (32'(i) * 32'h9E37_79B1));
      mem[i]  = gold[i];
    end

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ev_valid after reset", ev_valid, 0);
    chk("R1", "heartbeat after reset", heartbeat, 0);
    chk("R1", "crit_alarm after reset", crit_alarm, 0);
    repeat (3 * DIV) @(negedge clk);
    chk("R7", "no access without external tick", nrd + nwr, 0);

    // initialisation pass: order and silence
    run_pass();
    chk("R2", "reads in init pass", nrd, NA);
    for (int i = 0; i < NA; i++) chk("R2", "read order", rd_log[i], i);
    chk("R5", "no record in init pass", nev, 0);
    chk("R3", "no write on clean data", nwr, 0);
    run_pass();
    chk("R5", "no record on matching pass", nev, 0);
    chk("R6", "heartbeat toggles per frame", hb_tog, 2 * NF);

    // single-bit sweep over every codeword position
    for (int b = 0; b < 39; b++) begin
      a = (b * 5) % NA;
      mem[a][b] = ~mem[a][b];
      e0 = nev; c0 = ncrit;
      ee = ess_model(a, b);
      run_pass();
      chk("R3", "one record per single upset", nev - e0, 1);
      chk("R3", "record type corrected", r_type[e0 & 7], 1);
      chk("R3", "record frame", r_frame[e0 & 7], a / NW);
      chk("R3", "record word", r_word[e0 & 7], a % NW);
      chk("R3", "record bit", r_bit[e0 & 7], b);
      chk("R8", "essential flag", r_ess[e0 & 7], ee);
      chk("R8", "alarm pulses", ncrit - c0, ee);
      chk("R3", "word repaired", mem[a], gold[a]);
    end

    // double upset
    e0 = nev; w0 = nwr;
    mem[5][3] = ~mem[5][3];
    mem[5][20] = ~mem[5][20];
    run_pass();
    chk("R4", "records for double upset", nev - e0, 2);
    chk("R4", "type uncorrectable", r_type[e0 & 7], 2);
    chk("R4", "frame", r_frame[e0 & 7], 1);
    chk("R4", "word", r_word[e0 & 7], 1);
    chk("R4", "essential", r_ess[e0 & 7], 1);
    chk("R4", "no write", nwr - w0, 0);
    chk("R4", "word left unchanged", mem[5], gold[5] ^ 39'h10_0008);
    chk("R5", "crc mismatch type", r_type[(e0 + 1) & 7], 3);
    chk("R5", "crc mismatch frame", r_frame[(e0 + 1) & 7], 0);
    mem[5] = gold[5];
    e0 = nev;
    run_pass();
    chk("R5", "no record once restored", nev - e0, 0);

    // injection through the port
    inject(2, 2, 9);
    chk("R10", "injected bit flipped", mem[10], gold[10] ^ (39'd1 << 9));
    e0 = nev;
    run_pass();
    chk("R10", "injected upset reported", nev - e0, 1);
    chk("R10", "injected frame", r_frame[e0 & 7], 2);
    chk("R10", "injected word", r_word[e0 & 7], 2);
    chk("R10", "injected bit", r_bit[e0 & 7], 9);
    chk("R10", "injected word repaired", mem[10], gold[10]);

    // injection and tick in the same cycle
    e0 = nev;
    @(negedge clk);
    t0 = hb_tog;
    ext_tick = 1'b1;
    inj_frame = 2'd0; inj_word = 2'd2; inj_bit = 6'd17; inj_valid = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0; inj_valid = 1'b0;
    while (hb_tog == t0) @(negedge clk);
    @(negedge clk);
    chk("R10", "collision: reported in same frame", nev - e0, 1);
    chk("R10", "collision: frame", r_frame[e0 & 7], 0);
    chk("R10", "collision: word", r_word[e0 & 7], 2);
    chk("R10", "collision: bit", r_bit[e0 & 7], 17);
    chk("R10", "collision: repaired", mem[2], gold[2]);
    repeat (NF - 1) run_frame();

    // back-pressure with two upsets in one frame
    e0 = nev;
    ev_ready = 1'b0;
    mem[0][5] = ~mem[0][5];
    mem[1][33] = ~mem[1][33];
    t0 = hb_tog;
    @(negedge clk) ext_tick = 1'b1;
    @(negedge clk) ext_tick = 1'b0;
    repeat (30) @(negedge clk);
    chk("R9", "record held", ev_valid, 1);
    chk("R9", "held type", ev_type, 1);
    chk("R9", "held word", ev_word, 0);
    chk("R9", "held bit", ev_bit, 5);
    chk("R9", "scan stalled", hb_tog - t0, 0);
    chk("R9", "second word untouched", mem[1], gold[1] ^ (39'd1 << 33));
    ev_ready = 1'b1;
    while (hb_tog == t0) @(negedge clk);
    @(negedge clk);
    chk("R9", "two records delivered", nev - e0, 2);
    chk("R9", "second record word", r_word[(e0 + 1) & 7], 1);
    chk("R9", "second record bit", r_bit[(e0 + 1) & 7], 33);
    chk("R3", "both repaired", {mem[0] == gold[0], mem[1] == gold[1]}, 2'b11);
    repeat (NF - 1) run_frame();

    // internal tick source
    e0 = nev;
    use_ext_tick = 1'b0;
    t0 = hb_tog;
    repeat (10 * DIV) @(negedge clk);
    chk("R7", "internal ticks advance scan", (hb_tog - t0 >= 9) && (hb_tog - t0 <= 11), 1);
    chk("R5", "no record with clean data", nev - e0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule